// File: doc/BRIEF.md
# Two-Layer Modular Butterfly Array for Polynomial Transforms

This block is the arithmetic core of a number-theoretic transform engine for polynomials over the prime field of 3329, used with 256-coefficient polynomials. Each clock cycle it accepts a group of four coefficients and three twiddle factors. It pushes the group through two butterfly layers of two butterflies each, so one pass completes two transform iterations. A surrounding controller owns the coefficient memory, the twiddle table and the address order. It streams groups in and writes the results back.

In forward mode both layers use decimation-in-time butterflies. The wide pairs go first and the narrow pairs second. In inverse mode both layers use decimation-in-frequency butterflies, and the order is reversed: the narrow pairs first, then the wide pairs. Twiddle products use Montgomery multiplication with radix 2^16. Sums and differences are brought back into range by Barrett reduction. A skip control lets the second layer pass data through unchanged, which serves the seventh, odd iteration of a full transform. In inverse mode an optional closing Montgomery reduction scales every output by 2^-16 mod 3329.

Top module: `ntt_bfly_array`

## Requirements
- R1: `out_valid` repeats `in_valid` exactly 4 clock edges later. While `rst_n` is low, `out_valid` and `coef_out` are 0.
- R2: In forward mode, the first layer applies x = a + M(b,w) and y = a - M(b,w) (mod 3329) to lane pairs (0,2) and (1,3), with w = `root_wide`. Here M(u,w) = u*w*2^-16 mod 3329.
- R3: In forward mode without skip, the second layer applies the same butterfly to lane pairs (0,1) with `root_lo` and (2,3) with `root_hi`.
- R4: In inverse mode, the first layer applies x = a + b and y = M(a - b, w) (mod 3329) to lane pairs (0,1) with `root_lo` and (2,3) with `root_hi`.
- R5: In inverse mode without skip, the second layer applies the R4 butterfly to lane pairs (0,2) and (1,3), with `root_wide`.
- R6: With `skip_second` high, the second layer passes its four lanes unchanged, and the first layer still acts as in R2 or R4.
- R7: With `inverse` and `final_mont` both high, every output lane is multiplied by 2^-16 mod 3329. In forward mode `final_mont` has no effect.
- R8: For inputs below 3329, every output lane is below 3329.
- R9: A new group is accepted on every cycle. Mode, skip, scaling and twiddles travel with their own group, so back-to-back groups with different settings do not mix.
- R10: Lane i occupies bits [16i+15:16i] of `coef_in` and `coef_out`. It holds a 12-bit value, and the upper 4 bits of each output lane are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input group is valid this cycle |
| inverse | input | 1 | 1 selects inverse (decimation-in-frequency) mode |
| skip_second | input | 1 | Second layer passes data through |
| final_mont | input | 1 | Apply closing Montgomery scaling (inverse mode only) |
| root_wide | input | 16 | Twiddle for the wide-pair layer |
| root_lo | input | 16 | Twiddle for narrow pair (0,1) |
| root_hi | input | 16 | Twiddle for narrow pair (2,3) |
| coef_in | input | 64 | Four input coefficient lanes |
| out_valid | output | 1 | Output group is valid |
| coef_out | output | 64 | Four result coefficient lanes |

## Verification
The bench builds the block with its default parameters: modulus 3329, 16-bit lanes and a four-register pipeline. These values make the extreme operands reachable directly: 3328 in every lane, zero twiddles and twiddles of 3328. The same build gives every pairing of mode, skip and scaling on consecutive cycles, with bubbles between some groups. A behavioural model works in plain integer modular arithmetic with a precomputed inverse of 2^16. It predicts each group four cycles ahead, and the outputs are compared with it on every cycle.

// File: rtl/ntt_bfly_pkg.sv
package ntt_bfly_pkg;

  localparam int unsigned Q         = 3329;
  localparam int unsigned CW        = 16;
  localparam int unsigned LANES     = 4;
  localparam int unsigned PAIRS     = LANES / 2;
  localparam int unsigned BUS_W     = LANES * CW;
  localparam int unsigned LATENCY   = 4;
  localparam int unsigned BAR_SHIFT = 24;
  localparam int unsigned BAR_M     = (1 << BAR_SHIFT) / Q;

  typedef logic [CW-1:0] coef_t;

  // -q^-1 mod 2^CW by Newton iteration (precision doubles each step)
  function automatic logic [CW-1:0] neg_inverse();
    logic [CW-1:0] qv;
    logic [CW-1:0] inv;
    qv  = CW'(Q);
    inv = qv;
    for (int i = 0; i < 5; i++) begin
      inv = inv * (CW'(2) - qv * inv);
    end
    return CW'(0) - inv;
  endfunction

  localparam logic [CW-1:0] QNEG = neg_inverse();

  // Barrett reduction of a value below 2^(CW+1)
  function automatic coef_t barrett(input logic [CW:0] x);
    logic [47:0] prod;
    logic [47:0] r;
    prod = 48'(x) * 48'(BAR_M);
    r    = 48'(x) - (prod >> BAR_SHIFT) * 48'(Q);
    if (r >= 48'(Q)) r = r - 48'(Q);
    return r[CW-1:0];
  endfunction

  function automatic coef_t mod_add(input coef_t a, input coef_t b);
    return barrett({1'b0, a} + {1'b0, b});
  endfunction

  function automatic coef_t mod_sub(input coef_t a, input coef_t b);
    return barrett({1'b0, a} + (CW+1)'(Q) - {1'b0, b});
  endfunction

  // Montgomery product a*w*2^-CW mod Q
  function automatic coef_t mont_mul(input coef_t a, input coef_t w);
    logic [47:0]   p;
    logic [47:0]   s;
    logic [47:0]   t;
    logic [CW-1:0] m;
    p = 48'(a) * 48'(w);
    m = p[CW-1:0] * QNEG;
    s = p + 48'(m) * 48'(Q);
    t = s >> CW;
    if (t >= 48'(Q)) t = t - 48'(Q);
    return t[CW-1:0];
  endfunction

endpackage

// File: rtl/ntt_butterfly.sv
module ntt_butterfly
  import ntt_bfly_pkg::*;
(
  input  logic  gs,
  input  coef_t a,
  input  coef_t b,
  input  coef_t w,
  output coef_t x,
  output coef_t y
);

  coef_t twiddled;
  coef_t diff;

  always_comb begin
    diff     = mod_sub(a, b);
    twiddled = mont_mul(gs ? diff : b, w);
    if (gs) begin
      x = mod_add(a, b);
      y = twiddled;
    end else begin
      x = mod_add(a, twiddled);
      y = mod_sub(a, twiddled);
    end
  end

endmodule

// File: rtl/ntt_stage.sv
module ntt_stage
  import ntt_bfly_pkg::*;
#(
  parameter bit SECOND = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             v_in,
  input  logic             inv_in,
  input  logic             scl_in,
  input  logic             skip_in,
  input  logic [BUS_W-1:0] coef_in,
  input  logic [CW-1:0]    w_wide,
  input  logic [CW-1:0]    w_lo,
  input  logic [CW-1:0]    w_hi,
  output logic             v_out,
  output logic             inv_out,
  output logic             scl_out,
  output logic [BUS_W-1:0] coef_out
);

  coef_t lane_in [LANES];
  coef_t lane_nx [LANES];
  coef_t lane_q  [LANES];
  coef_t bx [PAIRS];
  coef_t by [PAIRS];
  logic  narrow;

  // first layer: forward->wide, inverse->narrow; second layer swaps
  assign narrow = SECOND ? ~inv_in : inv_in;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_in[i]            = coef_in[i*CW +: CW];
    assign coef_out[i*CW +: CW]  = lane_q[i];

    p_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      v_out |-> (32'(lane_q[i]) < Q));
  end

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    coef_t a, b, w;
    assign a = narrow ? lane_in[2*k]   : lane_in[k];
    assign b = narrow ? lane_in[2*k+1] : lane_in[k+PAIRS];
    assign w = narrow ? ((k == 0) ? w_lo : w_hi) : w_wide;

    ntt_butterfly u_bf (
      .gs (inv_in),
      .a  (a),
      .b  (b),
      .w  (w),
      .x  (bx[k]),
      .y  (by[k])
    );

    // R2 R3: CT outputs sum to twice the upper input
    p_ct_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (v_in && !inv_in) |->
        (((32'(bx[k]) + 32'(by[k])) % Q) == ((2 * 32'(a)) % Q)));
    // R4 R5: GS upper output is the modular sum
    p_gs_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (v_in && inv_in) |-> (32'(bx[k]) == ((32'(a) + 32'(b)) % Q)));
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) lane_nx[i] = lane_in[i];
    if (!skip_in) begin
      for (int k = 0; k < PAIRS; k++) begin
        if (narrow) begin
          lane_nx[2*k]   = bx[k];
          lane_nx[2*k+1] = by[k];
        end else begin
          lane_nx[k]       = bx[k];
          lane_nx[k+PAIRS] = by[k];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_out   <= 1'b0;
      inv_out <= 1'b0;
      scl_out <= 1'b0;
      for (int i = 0; i < LANES; i++) lane_q[i] <= '0;
    end else begin
      v_out   <= v_in;
      inv_out <= inv_in;
      scl_out <= scl_in;
      for (int i = 0; i < LANES; i++) lane_q[i] <= lane_nx[i];
    end
  end

  p_valid_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
    v_in |=> v_out);
  p_valid_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !v_in |=> !v_out);
  p_skip_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    skip_in |=> (coef_out == $past(coef_in)));
  p_mode_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    v_in |=> (inv_out == $past(inv_in)));

endmodule

// File: rtl/ntt_out_scale.sv
module ntt_out_scale
  import ntt_bfly_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             v_in,
  input  logic             inv_in,
  input  logic             scl_in,
  input  logic [BUS_W-1:0] coef_in,
  output logic             v_out,
  output logic [BUS_W-1:0] coef_out
);

  logic  apply;
  coef_t lane_in [LANES];
  coef_t lane_q  [LANES];

  assign apply = inv_in & scl_in;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_in[i]           = coef_in[i*CW +: CW];
    assign coef_out[i*CW +: CW] = lane_q[i];

    // R7: scaled output times 2^CW returns the input residue
    p_scale_val_r7: assert property (@(posedge clk) disable iff (!rst_n)
      apply |=> (((64'(lane_q[i]) << CW) % 64'(Q)) ==
                 (64'($past(lane_in[i])) % 64'(Q))));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_out <= 1'b0;
      for (int i = 0; i < LANES; i++) lane_q[i] <= '0;
    end else begin
      v_out <= v_in;
      for (int i = 0; i < LANES; i++)
        lane_q[i] <= apply ? mont_mul(lane_in[i], CW'(1)) : lane_in[i];
    end
  end

  p_scale_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> (coef_out == $past(coef_in)));
  p_valid_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    v_in |=> v_out);

endmodule

// File: rtl/ntt_bfly_array.sv
module ntt_bfly_array
  import ntt_bfly_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             inverse,
  input  logic             skip_second,
  input  logic             final_mont,
  input  logic [CW-1:0]    root_wide,
  input  logic [CW-1:0]    root_lo,
  input  logic [CW-1:0]    root_hi,
  input  logic [BUS_W-1:0] coef_in,
  output logic             out_valid,
  output logic [BUS_W-1:0] coef_out
);

  // input register stage
  logic             v0, inv0, scl0, skip0;
  logic [BUS_W-1:0] c0;
  logic [CW-1:0]    ww0, wl0, wh0;
  // side-band carried to the second layer
  logic             skip1;
  logic [CW-1:0]    ww1, wl1, wh1;

  logic             v1, inv1, scl1;
  logic [BUS_W-1:0] c1;
  logic             v2, inv2, scl2;
  logic [BUS_W-1:0] c2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v0 <= 1'b0; inv0 <= 1'b0; scl0 <= 1'b0; skip0 <= 1'b0;
      c0 <= '0; ww0 <= '0; wl0 <= '0; wh0 <= '0;
      skip1 <= 1'b0; ww1 <= '0; wl1 <= '0; wh1 <= '0;
    end else begin
      v0 <= in_valid; inv0 <= inverse; scl0 <= final_mont;
      skip0 <= skip_second;
      c0 <= coef_in; ww0 <= root_wide; wl0 <= root_lo; wh0 <= root_hi;
      skip1 <= skip0; ww1 <= ww0; wl1 <= wl0; wh1 <= wh0;
    end
  end

  ntt_stage #(.SECOND(1'b0)) u_layer_a (
    .clk (clk), .rst_n (rst_n),
    .v_in (v0), .inv_in (inv0), .scl_in (scl0), .skip_in (1'b0),
    .coef_in (c0), .w_wide (ww0), .w_lo (wl0), .w_hi (wh0),
    .v_out (v1), .inv_out (inv1), .scl_out (scl1), .coef_out (c1)
  );

  ntt_stage #(.SECOND(1'b1)) u_layer_b (
    .clk (clk), .rst_n (rst_n),
    .v_in (v1), .inv_in (inv1), .scl_in (scl1), .skip_in (skip1),
    .coef_in (c1), .w_wide (ww1), .w_lo (wl1), .w_hi (wh1),
    .v_out (v2), .inv_out (inv2), .scl_out (scl2), .coef_out (c2)
  );

  ntt_out_scale u_scale (
    .clk (clk), .rst_n (rst_n),
    .v_in (v2), .inv_in (inv2), .scl_in (scl2), .coef_in (c2),
    .v_out (out_valid), .coef_out (coef_out)
  );

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (v0 && (c0 == $past(coef_in))));
  p_skip_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (skip1 == $past(skip0)));

  for (genvar i = 0; i < LANES; i++) begin : g_pad
    p_pad_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (coef_out[i*CW+12 +: CW-12] == '0));
  end

endmodule

// File: tb/sim_ntt_bfly_array.sv
module sim_ntt_bfly_array;

  localparam int Q    = 3329;
  localparam int LAT  = 4;
  localparam int NRUN = 600;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, inverse = 1'b0, skip_second = 1'b0, final_mont = 1'b0;
  logic [15:0] root_wide = '0, root_lo = '0, root_hi = '0;
  logic [63:0] coef_in = '0;
  logic        out_valid;
  logic [63:0] coef_out;

  always #10 clk = ~clk;

  ntt_bfly_array u0 (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .inverse (inverse),
    .skip_second (skip_second), .final_mont (final_mont),
    .root_wide (root_wide), .root_lo (root_lo), .root_hi (root_hi),
    .coef_in (coef_in), .out_valid (out_valid), .coef_out (coef_out)
  );

  int n_chk = 0, n_fail = 0, rinv = 0;
  bit done = 1'b0;
  int ev [8];
  int ec [8][4];
  string etag [8];
  int cur [4];
  int cw, clo, chi;
  bit cinv, cskip, cscl, cval;

  function automatic int mm(int a, int w);
    return (((a * w) % Q) * rinv) % Q;
  endfunction

  function automatic string tag_of(bit inv, bit skp, bit scl);
    if (skp) return "R6";
    if (inv) return scl ? "R7" : "R4 R5";
    return "R2 R3";
  endfunction

  // behavioural reference: integer butterflies
  function automatic void model();
    int t, s, d;
    if (!cinv) begin
      for (int k = 0; k < 2; k++) begin
        t = mm(cur[k+2], cw);
        s = (cur[k] + t) % Q; d = (cur[k] - t + Q) % Q;
        cur[k] = s; cur[k+2] = d;
      end
      if (!cskip) begin
        for (int k = 0; k < 2; k++) begin
          t = mm(cur[2*k+1], (k == 0) ? clo : chi);
          s = (cur[2*k] + t) % Q; d = (cur[2*k] - t + Q) % Q;
          cur[2*k] = s; cur[2*k+1] = d;
        end
      end
    end else begin
      for (int k = 0; k < 2; k++) begin
        s = (cur[2*k] + cur[2*k+1]) % Q;
        d = mm((cur[2*k] - cur[2*k+1] + Q) % Q, (k == 0) ? clo : chi);
        cur[2*k] = s; cur[2*k+1] = d;
      end
      if (!cskip) begin
        for (int k = 0; k < 2; k++) begin
          s = (cur[k] + cur[k+2]) % Q;
          d = mm((cur[k] - cur[k+2] + Q) % Q, cw);
          cur[k] = s; cur[k+2] = d;
        end
      end
      if (cscl) for (int i = 0; i < 4; i++) cur[i] = (cur[i] * rinv) % Q;
    end
  endfunction

  task automatic check_eq(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(int t);
    cval = ($urandom_range(9) != 0);
    cinv = 1'($urandom_range(1)); cskip = ($urandom_range(3) == 0);
    cscl = 1'($urandom_range(1));
    cw = $urandom_range(Q-1); clo = $urandom_range(Q-1); chi = $urandom_range(Q-1);
    for (int i = 0; i < 4; i++) cur[i] = $urandom_range(Q-1);
    case (t)
      0: begin cval = 1; cinv = 0; cskip = 0; cscl = 0; cw = Q-1; clo = Q-1; chi = Q-1;
               for (int i = 0; i < 4; i++) cur[i] = Q-1; end
      1: begin cval = 1; cinv = 1; cskip = 0; cscl = 1; cw = 1; clo = 1; chi = 1;
               cur[0] = Q-1; cur[1] = 0; cur[2] = Q-1; cur[3] = 0; end
      2: begin cval = 1; cinv = 0; cskip = 1; cscl = 0; cw = 17; clo = 0; chi = Q-1;
               for (int i = 0; i < 4; i++) cur[i] = i + 1; end
      3: begin cval = 1; cinv = 1; cskip = 1; cscl = 1; end
      4: begin cval = 1; cinv = 0; cskip = 0; cscl = 1; end  // R7: flag ignored forward
      5: cval = 0;
      6: begin cval = 1; cinv = 1; cskip = 0; cscl = 0; cw = 0; clo = 0; chi = 0; end
      default: ;
    endcase
    if (t >= NRUN) cval = 0;
    in_valid = cval; inverse = cinv; skip_second = cskip; final_mont = cscl;
    root_wide = 16'(cw); root_lo = 16'(clo); root_hi = 16'(chi);
    coef_in = {16'(cur[3]), 16'(cur[2]), 16'(cur[1]), 16'(cur[0])};
    ev[t % 8] = int'(cval);
    etag[t % 8] = tag_of(cinv, cskip, cscl);
    model();
    for (int i = 0; i < 4; i++) ec[t % 8][i] = cur[i];
  endtask

  initial begin
    for (int r = 1; r < Q; r++) if (((65536 * r) % Q) == 1) rinv = r;
    repeat (3) @(negedge clk);
    check_eq("R1 reset out_valid", int'(out_valid), 0);
    check_eq("R1 reset coef_out", (coef_out == 64'd0) ? 0 : 1, 0);
    for (int t = 0; t < NRUN + LAT; t++) begin
      @(negedge clk);
      if (t == 0) rst_n = 1'b1;
      if (t >= LAT) begin
        int s;
        s = (t - LAT) % 8;
        // R1 R9: valid follows each accepted group, one per cycle
        check_eq("R1 R9 out_valid", int'(out_valid), ev[s]);
        if (ev[s] != 0) begin
          for (int i = 0; i < 4; i++) begin
            // R10: full 16-bit lane compared, upper bits must be zero
            check_eq({etag[s], " R10 lane"}, int'(coef_out[i*16 +: 16]), ec[s][i]);
            check_eq("R8 lane below modulus", (int'(coef_out[i*16 +: 16]) < Q) ? 1 : 0, 1);
          end
        end
      end else begin
        check_eq("R1 empty pipeline", int'(out_valid), 0);
      end
      drive(t);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule